// File: doc/BRIEF.md
# Round-Robin Warp Issue Scheduler

This block chooses which resident warp sends its next instruction into a narrow execution pipeline. The pipeline has fewer lanes than a warp has threads, so one warp instruction holds the issue port for several consecutive cycles. The port processes one lane group per cycle. With the defaults of 32 threads and 8 lanes, this is 4 cycles. A new choice is made only when the port is about to free up.

Each warp carries a countdown that starts when the warp issues. If the warp's next instruction needs the result of its previous one, the warp waits until that countdown has run out. The result latency defaults to 24 cycles. Warps that are waiting on memory, or that are parked at a barrier, are skipped. A single release pulse frees every parked warp in the same cycle.

Selection is round-robin, starting from the warp after the last one issued. The block also reports:
- a retire pulse, exactly one result latency after each issue;
- a count of cycles in which the port was free but no warp could go.

With the default latency, six or more warps with chained dependencies keep the port busy in every cycle.

Top module: `warp_issue_sched`

## Requirements
- R1: While `rst` is high, and in the cycle after it goes low, `issue_valid`, `retire_valid` and `lane_grp` are 0 and `stall_count` is 0. The first warp issued after reset is the lowest-numbered eligible warp, counting from warp 0.
- R2: Two `issue_valid` pulses are never closer than SLOT_CYC = THREADS/LANES cycles. In the cycle of an issue, `lane_grp` equals 1 (bit 0). In each following cycle of the same instruction, the set bit moves up by one position.
- R3: The warp issued is the first eligible warp found by searching cyclically upward, starting from the warp after the one issued last.
- R4: A warp whose `warp_dep` bit is 1 issues no sooner than LATENCY cycles after its own previous issue. A single dependent warp therefore issues exactly every LATENCY cycles.
- R5: A warp whose `warp_dep` bit is 0 ignores its countdown. A single such warp issues every SLOT_CYC cycles.
- R6: A warp whose `warp_mem_wait` bit is 1 is never issued.
- R7: A pulse on bit w of `bar_arrive` parks warp w, and a parked warp never issues. A single-cycle `bar_release` unparks every parked warp at once.
- R8: `retire_valid` pulses exactly LATENCY cycles after each `issue_valid`, with `retire_wid` equal to that issue's warp number. A reset discards every instruction in flight.
- R9: `stall_count` rises by one in each cycle where the port is free (idle, or in the last cycle of an instruction) and no warp is eligible. It does not move in a cycle that leads to an issue.
- R10: With six dependent warps, and the default LATENCY of 24, exactly one issue occurs every 4 cycles. With four dependent warps, exactly 4 issues occur per 24 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| warp_ready | input | NUM_WARPS | Warp has a next instruction |
| warp_dep | input | NUM_WARPS | Next instruction reads the previous result |
| warp_mem_wait | input | NUM_WARPS | Warp waits on memory |
| bar_arrive | input | NUM_WARPS | Pulse: park warp at the barrier |
| bar_release | input | 1 | Pulse: unpark all parked warps |
| issue_valid | output | 1 | Issue strobe, first lane-group cycle |
| issue_wid | output | WID_W | Warp number issued |
| lane_grp | output | SLOT_CYC | One-hot lane group on the port this cycle |
| retire_valid | output | 1 | Result of an issued instruction is ready |
| retire_wid | output | WID_W | Warp number retiring |
| stall_count | output | STALL_W | Wrapping count of empty issue slots |

## Verification
The scheduler makes its decision at a clock edge, from that cycle's inputs and its own state. `issue_valid` and lane group 0 appear in the cycle right after that edge. The remaining lane groups follow, one per cycle, and the retire pulse arrives exactly LATENCY cycles after the issue cycle.

The bench drives inputs 1 ns after a rising edge and samples on the falling edge. Each time it sees an issue, it pushes the expected retire (warp number and due cycle) into a queue, and it checks each retire against the head of that queue. Issue spacing is checked against the cycle of the previous issue. Issue order is checked against the warp that came before.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;

    typedef enum logic {
        PORT_IDLE = 1'b0,
        PORT_BUSY = 1'b1
    } port_state_e;

    function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

    function automatic int unsigned idx_bits(input int unsigned count);
        return (count > 1) ? $clog2(count) : 1;
    endfunction

endpackage

// File: rtl/ws_rr_pick.sv
module ws_rr_pick #(
    parameter int unsigned NUM_WARPS = 8,
    parameter int unsigned WID_W     = 3
) (
    input  logic [NUM_WARPS-1:0] eligible,
    input  logic [WID_W-1:0]     start,
    output logic                 found,
    output logic [WID_W-1:0]     pick
);
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int k = 0; k < int'(NUM_WARPS); k++) begin
            int idx;
            idx = (int'(start) + k) % int'(NUM_WARPS);
            if (!found && eligible[idx]) begin
                found = 1'b1;
                pick  = WID_W'(idx);
            end
        end
    end
endmodule

// File: rtl/ws_scoreboard.sv
module ws_scoreboard #(
    parameter int unsigned NUM_WARPS = 8,
    parameter int unsigned WID_W     = 3,
    parameter int unsigned LATENCY   = 24
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load_en,
    input  logic [WID_W-1:0]     load_wid,
    input  logic [NUM_WARPS-1:0] ready,
    input  logic [NUM_WARPS-1:0] dep,
    input  logic [NUM_WARPS-1:0] mem_wait,
    input  logic [NUM_WARPS-1:0] bar_arrive,
    input  logic                 bar_release,
    output logic [NUM_WARPS-1:0] eligible
);
    localparam int unsigned CD_W = $clog2(LATENCY + 1);

    logic [NUM_WARPS-1:0] parked;

    always_ff @(posedge clk) begin
        if (rst) parked <= '0;
        else     parked <= (bar_release ? '0 : parked) | bar_arrive;
    end

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
        logic [CD_W-1:0] countdown;

        always_ff @(posedge clk) begin
            if (rst)
                countdown <= '0;
            else if (load_en && load_wid == WID_W'(w))
                countdown <= CD_W'(LATENCY - 1);
            else if (countdown != '0)
                countdown <= countdown - 1'b1;
        end

        assign eligible[w] = ready[w] & ~mem_wait[w] & ~parked[w]
                           & (~dep[w] | (countdown == '0));
    end
endmodule

// File: rtl/ws_delay_line.sv
module ws_delay_line #(
    parameter int unsigned DEPTH = 24,
    parameter int unsigned W     = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_vld,
    input  logic [W-1:0] in_data,
    output logic         out_vld,
    output logic [W-1:0] out_data
);
    logic [DEPTH-1:0] vld;
    logic [W-1:0]     dat [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) vld <= '0;
        else     vld <= {vld[DEPTH-2:0], in_vld};
    end

    always_ff @(posedge clk) dat[0] <= in_data;

    for (genvar s = 1; s < DEPTH; s++) begin : g_stage
        always_ff @(posedge clk) dat[s] <= dat[s-1];
    end

    assign out_vld  = vld[DEPTH-1];
    assign out_data = dat[DEPTH-1];
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
    import warp_sched_pkg::*;
#(
    parameter int unsigned NUM_WARPS = 8,
    parameter int unsigned THREADS   = 32,
    parameter int unsigned LANES     = 8,
    parameter int unsigned LATENCY   = 24,
    parameter int unsigned STALL_W   = 16,
    localparam int unsigned SLOT_CYC = ceil_div(THREADS, LANES),
    localparam int unsigned WID_W    = idx_bits(NUM_WARPS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_WARPS-1:0] warp_ready,
    input  logic [NUM_WARPS-1:0] warp_dep,
    input  logic [NUM_WARPS-1:0] warp_mem_wait,
    input  logic [NUM_WARPS-1:0] bar_arrive,
    input  logic                 bar_release,
    output logic                 issue_valid,
    output logic [WID_W-1:0]     issue_wid,
    output logic [SLOT_CYC-1:0]  lane_grp,
    output logic                 retire_valid,
    output logic [WID_W-1:0]     retire_wid,
    output logic [STALL_W-1:0]   stall_count
);
    localparam int unsigned PH_W = idx_bits(SLOT_CYC);

    port_state_e          port_st;
    logic [PH_W-1:0]      phase;
    logic [WID_W-1:0]     rr_ptr;
    logic [NUM_WARPS-1:0] eligible;
    logic                 any_elig;
    logic [WID_W-1:0]     pick;
    logic                 slot_open;
    logic                 fire;

    ws_scoreboard #(
        .NUM_WARPS (NUM_WARPS),
        .WID_W     (WID_W),
        .LATENCY   (LATENCY)
    ) u_sb (
        .clk         (clk),
        .rst         (rst),
        .load_en     (fire),
        .load_wid    (pick),
        .ready       (warp_ready),
        .dep         (warp_dep),
        .mem_wait    (warp_mem_wait),
        .bar_arrive  (bar_arrive),
        .bar_release (bar_release),
        .eligible    (eligible)
    );

    ws_rr_pick #(
        .NUM_WARPS (NUM_WARPS),
        .WID_W     (WID_W)
    ) u_pick (
        .eligible (eligible),
        .start    (rr_ptr),
        .found    (any_elig),
        .pick     (pick)
    );

    // Port frees when idle or on the last lane group of the current warp.
    assign slot_open = (port_st == PORT_IDLE) || (phase == PH_W'(SLOT_CYC - 1));
    assign fire      = slot_open && any_elig;

    always_ff @(posedge clk) begin
        if (rst) begin
            port_st     <= PORT_IDLE;
            phase       <= '0;
            issue_valid <= 1'b0;
            issue_wid   <= '0;
            rr_ptr      <= '0;
            stall_count <= '0;
        end else begin
            issue_valid <= fire;
            if (fire) begin
                issue_wid <= pick;
                rr_ptr    <= (pick == WID_W'(NUM_WARPS - 1)) ? '0 : pick + 1'b1;
                port_st   <= PORT_BUSY;
                phase     <= '0;
            end else if (port_st == PORT_BUSY) begin
                if (phase == PH_W'(SLOT_CYC - 1)) port_st <= PORT_IDLE;
                else                              phase   <= phase + 1'b1;
            end
            if (slot_open && !any_elig)
                stall_count <= stall_count + 1'b1;
        end
    end

    always_comb begin
        lane_grp = '0;
        if (port_st == PORT_BUSY) lane_grp[phase] = 1'b1;
    end

    ws_delay_line #(
        .DEPTH (LATENCY),
        .W     (WID_W)
    ) u_retire (
        .clk      (clk),
        .rst      (rst),
        .in_vld   (issue_valid),
        .in_data  (issue_wid),
        .out_vld  (retire_valid),
        .out_data (retire_wid)
    );
endmodule

// File: rtl/ws_sched_checker.sv
module ws_sched_checker #(
    parameter int unsigned NUM_WARPS = 8,
    parameter int unsigned THREADS   = 32,
    parameter int unsigned LANES     = 8,
    parameter int unsigned LATENCY   = 24,
    parameter int unsigned STALL_W   = 16,
    localparam int unsigned SLOT_CYC = warp_sched_pkg::ceil_div(THREADS, LANES),
    localparam int unsigned WID_W    = warp_sched_pkg::idx_bits(NUM_WARPS)
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_WARPS-1:0] warp_dep,
    input logic [NUM_WARPS-1:0] warp_mem_wait,
    input logic                 issue_valid,
    input logic [WID_W-1:0]     issue_wid,
    input logic [SLOT_CYC-1:0]  lane_grp,
    input logic [STALL_W-1:0]   stall_count
);
    int                   since_issue;
    int                   age [NUM_WARPS];
    logic [NUM_WARPS-1:0] dep_q;
    logic [NUM_WARPS-1:0] mem_q;

    always_ff @(posedge clk) begin
        dep_q <= warp_dep;
        mem_q <= warp_mem_wait;
        if (rst) begin
            since_issue <= int'(SLOT_CYC);
            for (int w = 0; w < int'(NUM_WARPS); w++) age[w] <= int'(LATENCY);
        end else begin
            if (issue_valid) since_issue <= 1;
            else if (since_issue < int'(SLOT_CYC)) since_issue <= since_issue + 1;
            for (int w = 0; w < int'(NUM_WARPS); w++) begin
                if (issue_valid && issue_wid == WID_W'(w)) age[w] <= 1;
                else if (age[w] < int'(LATENCY)) age[w] <= age[w] + 1;
            end
        end
    end

    AST_SLOT_SPACING: assert property (@(posedge clk) disable iff (rst)
        issue_valid |-> since_issue >= int'(SLOT_CYC)); // R2
    AST_LANE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lane_grp)); // R2
    AST_ISSUE_FIRST_GROUP: assert property (@(posedge clk) disable iff (rst)
        issue_valid |-> lane_grp == SLOT_CYC'(1)); // R2
    AST_DEP_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && dep_q[issue_wid]) |-> age[issue_wid] >= int'(LATENCY)); // R4
    AST_MEM_EXCLUDED: assert property (@(posedge clk) disable iff (rst)
        issue_valid |-> !mem_q[issue_wid]); // R6
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        issue_valid |-> $stable(stall_count)); // R9
endmodule

bind warp_issue_sched ws_sched_checker #(
    .NUM_WARPS (NUM_WARPS),
    .THREADS   (THREADS),
    .LANES     (LANES),
    .LATENCY   (LATENCY),
    .STALL_W   (STALL_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .warp_dep      (warp_dep),
    .warp_mem_wait (warp_mem_wait),
    .issue_valid   (issue_valid),
    .issue_wid     (issue_wid),
    .lane_grp      (lane_grp),
    .stall_count   (stall_count)
);

// File: tb/warp_issue_sched_tb.sv
`timescale 1ns/1ps
module warp_issue_sched_tb;
    localparam int N   = 8;
    localparam int LAT = 24;
    localparam int SC  = 4;
    localparam int WW  = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  warp_ready = '0, warp_dep = '0, warp_mem_wait = '0, bar_arrive = '0;
    logic          bar_release = 1'b0;
    logic          issue_valid, retire_valid;
    logic [WW-1:0] issue_wid, retire_wid;
    logic [SC-1:0] lane_grp;
    logic [15:0]   stall_count;

    warp_issue_sched u_dut (
        .clk(clk), .rst(rst), .warp_ready(warp_ready), .warp_dep(warp_dep),
        .warp_mem_wait(warp_mem_wait), .bar_arrive(bar_arrive), .bar_release(bar_release),
        .issue_valid(issue_valid), .issue_wid(issue_wid), .lane_grp(lane_grp),
        .retire_valid(retire_valid), .retire_wid(retire_wid), .stall_count(stall_count)
    );

    always #4 clk = ~clk;

    int total = 0, bad = 0, cyc = 0;
    int issue_n = 0, retire_n = 0;
    int last_wid = 0, last_cyc = 0, first_wid = -1;
    bit have_last = 0, have_first = 0;
    bit ord_on = 0, gap_on = 0;
    logic [N-1:0] ord_mask = '0;
    int gap_exp = 4;
    string gap_tag = "R10";
    int exp_wid_q[$];
    int exp_due_q[$];
    logic [SC-1:0] lane_prev = '0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic int next_of(input int last, input logic [N-1:0] m);
        for (int k = 1; k <= N; k++) begin
            if (m[(last + k) % N]) return (last + k) % N;
        end
        return -1;
    endfunction

    // Monitor: scoreboard of retires, order, spacing and lane-group checks.
    always @(negedge clk) begin
        if (rst) begin
            exp_wid_q.delete();
            exp_due_q.delete();
        end else begin
            if (retire_valid) begin
                retire_n++;
                if (exp_wid_q.size() == 0) begin
                    chk(1'b0, "R8", "unexpected retire", int'(retire_wid), -1);
                end else begin
                    int ew, ed;
                    ew = exp_wid_q.pop_front();
                    ed = exp_due_q.pop_front();
                    chk(int'(retire_wid) == ew, "R8", "retire warp", int'(retire_wid), ew);
                    chk(cyc == ed, "R8", "retire cycle", cyc, ed);
                end
            end
            if (lane_grp != '0 && lane_prev != '0 && !issue_valid)
                chk(lane_grp == (lane_prev << 1), "R2", "lane group step", int'(lane_grp), int'(lane_prev << 1));
            if (issue_valid) begin
                issue_n++;
                chk(lane_grp == 4'b0001, "R2", "lane group at issue", int'(lane_grp), 1);
                exp_wid_q.push_back(int'(issue_wid));
                exp_due_q.push_back(cyc + LAT);
                if (have_last) begin
                    if (gap_on) chk(cyc - last_cyc == gap_exp, gap_tag, "issue gap", cyc - last_cyc, gap_exp);
                    if (ord_on) chk(int'(issue_wid) == next_of(last_wid, ord_mask), "R3", "rr order",
                                    int'(issue_wid), next_of(last_wid, ord_mask));
                end
                if (!have_first) begin
                    first_wid  = int'(issue_wid);
                    have_first = 1;
                end
                have_last = 1;
                last_wid  = int'(issue_wid);
                last_cyc  = cyc;
            end
        end
        lane_prev <= lane_grp;
    end

    initial begin
        #(8 * 200000);
        chk(1'b0, "WD", "watchdog expired", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic arm(input logic [N-1:0] m, input bit o, input bit g, input int ge, input string gt);
        have_last = 0; ord_mask = m; ord_on = o; gap_on = g; gap_exp = ge; gap_tag = gt;
    endtask

    initial begin
        int s0;
        tick(3);
        chk(issue_valid == 0 && retire_valid == 0, "R1", "strobes in reset", int'(issue_valid), 0);
        chk(lane_grp == 0, "R1", "lanes in reset", int'(lane_grp), 0);
        chk(stall_count == 0, "R1", "stall in reset", int'(stall_count), 0);

        // Six dependent warps: full port, round-robin, start at warp 0.
        warp_ready = 8'h3F; warp_dep = 8'h3F;
        rst = 1'b0;
        chk(issue_valid == 0, "R1", "no issue right after reset", int'(issue_valid), 0);
        arm(8'h3F, 1, 1, 4, "R10");
        tick(20);
        chk(first_wid == 0, "R1", "first warp after reset", first_wid, 0);
        issue_n = 0; s0 = int'(stall_count);
        tick(240);
        chk(issue_n == 60, "R10", "issues with 6 dependent warps", issue_n, 60);
        chk(int'(stall_count) == s0, "R9", "no stall when full", int'(stall_count), s0);

        // Four dependent warps: idle slots.
        warp_ready = 8'h0F; warp_dep = 8'h0F;
        arm(8'h0F, 1, 0, 4, "R10");
        tick(60);
        issue_n = 0; s0 = int'(stall_count);
        tick(240);
        chk(issue_n == 40, "R10", "issues with 4 dependent warps", issue_n, 40);
        chk(int'(stall_count) - s0 == 80, "R9", "stall cycles", int'(stall_count) - s0, 80);

        // Single dependent warp waits the full latency.
        warp_ready = 8'h01; warp_dep = 8'h01;
        arm(8'h01, 0, 1, LAT, "R4");
        tick(300);

        // Single independent warp ignores the countdown.
        warp_dep = 8'h00;
        arm(8'h01, 0, 1, 4, "R5");
        tick(100);

        // Memory wait excludes warp 2.
        warp_ready = 8'h3F; warp_mem_wait = 8'h04;
        arm(8'h3B, 1, 1, 4, "R6");
        tick(100);
        warp_mem_wait = 8'h00;

        // Barrier: park warps 0..3, then release together.
        bar_arrive = 8'h0F; tick(1); bar_arrive = 8'h00;
        arm(8'h30, 0, 0, 4, "R7");
        tick(2);
        arm(8'h30, 1, 1, 4, "R7");
        issue_n = 0;
        tick(80);
        chk(issue_n == 20, "R7", "issues while parked", issue_n, 20);
        bar_release = 1'b1; tick(1); bar_release = 1'b0;
        arm(8'h3F, 0, 0, 4, "R7");
        tick(5);
        arm(8'h3F, 1, 1, 4, "R7");
        tick(60);

        // Reset with instructions in flight.
        warp_dep = 8'h3F;
        tick(30);
        rst = 1'b1; warp_ready = 8'h00; arm(8'h00, 0, 0, 4, "R1");
        tick(2);
        rst = 1'b0;
        chk(issue_valid == 0 && lane_grp == 0, "R1", "outputs after mid reset", int'(lane_grp), 0);
        chk(stall_count == 0, "R1", "stall after mid reset", int'(stall_count), 0);
        retire_n = 0;
        tick(LAT + 10);
        chk(retire_n == 0, "R8", "in-flight discarded by reset", retire_n, 0);
        have_first = 0;
        warp_ready = 8'h3F;
        tick(10);
        chk(first_wid == 0, "R1", "pointer back at warp 0", first_wid, 0);
        tick(60);
        warp_ready = 8'h00;
        tick(LAT + 10);
        chk(exp_wid_q.size() == 0, "R8", "all issues retired", exp_wid_q.size(), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule